// File: doc/BRIEF.md
# Byte-to-Halfword Load Unpack Unit

This stage sits on the load return path, just after the read data comes back from memory. It takes a small little-endian chunk of 2 or 4 bytes and widens each byte into its own 16-bit halfword lane. One load therefore yields a packed vector of extended elements rather than a single extended scalar. For each load the issuing instruction chooses whether every byte is zero-extended or sign-extended.

The result goes out through one register stage, and a valid flag moves in step with the data. A narrow (2-element) load fills a 32-bit destination. A wide (4-element) load fills a 64-bit register-pair destination. The lanes that a narrow load does not use are driven to zero. Address generation, the memory array and register writeback belong to other blocks.

Top module: `byte_unpack_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high exactly one clock cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: When `in_signed` = 0, the upper byte of every active halfword lane is 0x00, so a byte 0x81 becomes 0x0081.
- R4: When `in_signed` = 1, the upper byte of each active lane copies bit 7 of that lane's own byte (0x81 gives 0xff81, 0x02 gives 0x0002). Each lane decides independently of its neighbours.
- R5: Lanes are filled in little-endian order. Input byte k (`in_bytes[8k+7:8k]`) appears in the low byte of output lane k (`out_data[16k+7:16k]`).
- R6: When `in_quad` = 0 (2-element load), only bytes 0 and 1 are used. `out_data[63:32]` is zero, and input bytes 2 and 3 have no effect on the output.
- R7: When `in_quad` = 1 (4-element load), all four lanes are filled. For example, bytes 0x81,0x02,0x83,0x04, unsigned, give 0x0004008300020081.
- R8: After a cycle with `in_valid` low, `out_data` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A load chunk is present this cycle |
| in_bytes | input | 32 | Raw read bytes, lowest address in bits 7:0 |
| in_quad | input | 1 | 1 = 4 elements (64-bit result), 0 = 2 elements (32-bit result) |
| in_signed | input | 1 | 1 = sign-extend each byte, 0 = zero-extend |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Packed halfword lanes, lane 0 in bits 15:0 |

## Verification
The bench builds the unit with its default parameters: four lanes of 8-bit bytes. At that size, every byte value can be driven through every lane in both element counts and both extension modes. A byte sweep of 0 to 255 is spread across the lanes with different offsets, so each lane sees every sign pattern while its neighbours hold different values. That sweep exposes lane swaps and sign bits that leak between lanes. Directed vectors then cover the example result, the bytes that a narrow load must ignore, and holding the output while valid is low.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;

  typedef enum logic {
    ELEM_PAIR = 1'b0,
    ELEM_QUAD = 1'b1
  } elem_cnt_e;
endpackage

// File: rtl/lane_extend.sv
module lane_extend #(
  parameter int BYTE_W = unpack_pkg::BYTE_W,
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              sign_en,
  input  logic              lane_en,
  output logic [HALF_W-1:0] half_out
);
  logic fill_bit;

  // The fill depends only on this lane's own top bit.
  assign fill_bit = sign_en & byte_in[BYTE_W-1];

  always_comb begin
    if (lane_en) half_out = {{BYTE_W{fill_bit}}, byte_in};
    else         half_out = '0;
  end
endmodule

// File: rtl/unpack_lanes.sv
module unpack_lanes #(
  parameter int LANES  = 4,
  parameter int BYTE_W = unpack_pkg::BYTE_W,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int NARROW = LANES / 2
) (
  input  logic [LANES*BYTE_W-1:0] bytes_in,
  input  logic                    quad,
  input  logic                    sign_en,
  output logic [LANES*HALF_W-1:0] packed_out
);
  import unpack_pkg::*;

  elem_cnt_e cnt;
  assign cnt = elem_cnt_e'(quad);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic en;
    if (k < NARROW) begin : g_always_on
      assign en = 1'b1;
    end else begin : g_wide_only
      assign en = (cnt == ELEM_QUAD);
    end

    lane_extend #(.BYTE_W(BYTE_W)) u_ext (
      .byte_in  (bytes_in[k*BYTE_W +: BYTE_W]),
      .sign_en  (sign_en),
      .lane_en  (en),
      .half_out (packed_out[k*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/byte_unpack_unit.sv
module byte_unpack_unit #(
  parameter int LANES  = 4,
  parameter int BYTE_W = unpack_pkg::BYTE_W,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int IN_W   = LANES * BYTE_W,
  localparam int OUT_W  = LANES * HALF_W,
  localparam int NARROW = LANES / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_bytes,
  input  logic             in_quad,
  input  logic             in_signed,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic [OUT_W-1:0] lanes_next;

  unpack_lanes #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lanes (
    .bytes_in   (in_bytes),
    .quad       (in_quad),
    .sign_en    (in_signed),
    .packed_out (lanes_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lanes_next;
    end
  end

  // R2: valid tracks the input strobe with one cycle of latency
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid & ~rst));

  // R8: no new load leaves the data register untouched
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    $past(~rst & ~in_valid) |-> $stable(out_data));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    if (k < NARROW) begin : g_low
      // R5: byte k lands in the low byte of lane k
      a_r5_lane_byte: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid & ~rst) |->
          out_data[k*HALF_W +: BYTE_W] == $past(in_bytes[k*BYTE_W +: BYTE_W]));
      // R3/R4: upper byte is all copies of the lane's own sign, or zero
      a_r4_ext_byte: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid & ~rst) |->
          out_data[k*HALF_W+BYTE_W +: BYTE_W] ==
          {BYTE_W{$past(in_signed & in_bytes[k*BYTE_W+BYTE_W-1])}});
    end else begin : g_high
      // R7: wide loads fill the upper lanes too
      a_r7_wide_lane: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid & ~rst & in_quad) |->
          out_data[k*HALF_W +: BYTE_W] == $past(in_bytes[k*BYTE_W +: BYTE_W]));
      // R6: narrow loads leave the upper lanes zero
      a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid & ~rst & ~in_quad) |-> out_data[k*HALF_W +: HALF_W] == '0);
    end
  end
endmodule

// File: tb/byte_unpack_unit_tb.sv
`timescale 1ns/1ps
module byte_unpack_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_bytes = '0;
  logic        in_quad = 1'b0;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_unpack_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes),
    .in_quad(in_quad), .in_signed(in_signed),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [31:0] b, bit quad, bit sgn);
    logic [63:0] r = '0;
    int n = quad ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      int v = int'(b[8*k +: 8]);
      int h = v;
      if (sgn && v >= 128) h = v + 65280;
      r[16*k +: 16] = h[15:0];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drives one load, then samples the registered result one edge later.
  task automatic apply(logic [31:0] b, bit quad, bit sgn, string req);
    @(negedge clk);
    in_bytes = b; in_quad = quad; in_signed = sgn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {63'd0, out_valid}, 64'd1);
    check(req, out_data, model(b, quad, sgn));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    // R1: reset state, with an active strobe that must be ignored
    in_valid = 1'b1;
    in_bytes = 32'hffff_ffff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", out_data, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", out_data, 64'd0);

    // R7: the example chunk, both modes
    apply(32'h0483_0281, 1'b1, 1'b0, "R7");
    check("R7", out_data, 64'h0004_0083_0002_0081);
    apply(32'h0483_0281, 1'b1, 1'b1, "R4");
    check("R4", out_data, 64'h0004_ff83_0002_ff81);

    // R5: distinct bytes show lane order
    apply(32'h4433_2211, 1'b1, 1'b0, "R5");
    check("R5", out_data, 64'h0044_0033_0022_0011);

    // R6: upper bytes ignored on narrow loads
    apply(32'h0000_8102, 1'b0, 1'b1, "R6");
    check("R6", out_data, 64'h0000_0000_ff81_0002);
    apply(32'hffff_8102, 1'b0, 1'b1, "R6");
    check("R6", out_data, 64'h0000_0000_ff81_0002);

    // R8: output held while strobe low and other inputs change
    held = out_data;
    @(negedge clk);
    in_bytes = 32'h5a5a_5a5a; in_quad = 1'b1; in_signed = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", out_data, held);
    check("R2", {63'd0, out_valid}, 64'd0);

    // R3/R4/R6/R7: sweep every byte value through every lane
    for (int b = 0; b < 256; b++) begin
      logic [7:0] x = 8'(b);
      logic [31:0] v = {x ^ 8'ha5, x + 8'd97, ~x, x};
      apply(v, 1'b0, 1'b0, "R3");
      apply(v, 1'b0, 1'b1, "R6");
      apply(v, 1'b1, 1'b0, "R3");
      apply(v, 1'b1, 1'b1, "R4");
    end

    // R2: back-to-back loads, one result per cycle
    @(negedge clk);
    in_valid = 1'b1; in_quad = 1'b1; in_signed = 1'b0; in_bytes = 32'h0102_0304;
    @(negedge clk);
    in_bytes = 32'h8090_a0b0; in_signed = 1'b1;
    check("R2", out_data, 64'h0001_0002_0003_0004);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", out_data, 64'hff80_ff90_ffa0_ffb0);
    check("R2", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule